// File: doc/BRIEF.md
# Pin Function Multiplexer with Change Interrupts

This block controls six pins: four bidirectional pins (numbered 1, 3, 4 and 5) and two input-only pins (numbered 7 and 8). Each bidirectional pin has a 4-bit function code. The code either leaves the pin as an input or selects one of a fixed set of internal signals to drive out: a divided clock, constant low, constant high, PLL lock, temperature good, serial data, the block's own combined interrupt, microphone detect and microphone short. Pull-up and pull-down requests go straight through to the pad as control bits. The pad circuitry itself is outside this block, and so are the sources of the status signals.

Every pin input passes through the same chain. First comes an optional polarity inversion. Next comes an optional debounce, which works only while the timeout tick is enabled and a master clock is reported present. Last, the conditioned level is watched for changes. A change on an interrupt-enabled pin sets a sticky status bit. Software clears that bit by writing 1 to it. The interrupt output is the OR of all enabled status bits.

Software reaches the block through a simple synchronous port. Writes take effect on the clock edge. Read data is registered and appears in the cycle after the read strobe.

Top module: `gpio_mux_irq`

Register map (address, then contents):
- Addresses 0 to 3 configure pins 1, 3, 4 and 5 respectively:
  - bits [3:0] hold the function code;
  - bit 4 enables debounce;
  - bit 5 enables the interrupt;
  - bit 6 requests the pull-up;
  - bit 7 requests the pull-down.
- Address 4 configures the input-only pins:
  - pin 7 uses bit 0 for input enable, bit 1 for debounce and bit 2 for the interrupt;
  - pin 8 uses bit 3 for input enable, bit 4 for debounce and bit 5 for the interrupt.
- Address 5 holds the polarity register.
- Address 6 holds status in bits [5:0] and the conditioned levels in bits [13:8]. Both fields are in pin order 1, 3, 4, 5, 7, 8.
- Address 7, bit 0, is the timeout-tick enable.

## Requirements
- R1: After reset, every pad output enable, pull-up, pull-down and the interrupt output are 0, and every register reads back 0.
- R2: Function code 0010 drives the pin low and code 0011 drives it high, with the output enable set.
- R3: Codes 0001, 0100, 0101, 0110, 0111, 1000 and 1001 drive the pin from, in that order, the divided clock, PLL lock, temperature good, serial data, the combined interrupt output, microphone detect and microphone short, with the output enable set.
- R4: Code 0000 and the reserved codes 1010 to 1111 leave the output enable at 0.
- R5: Polarity register bits 0, 2, 3, 4, 6 and 7 invert pins 1, 3, 4, 5, 7 and 8 respectively (1 = inverted). Bits 1 and 5 read back as written and have no effect on any level.
- R6: While an input-only pin's enable bit is 0, its conditioned level reads 0 and it never sets its status bit.
- R7: When debounce, tick enable and master-clock-present are all set, the conditioned level takes a new value only after 4 consecutive tick pulses see that value. Any cycle in which the input equals the current level restarts the count. Otherwise the level follows the polarity-adjusted input one cycle later.
- R8: A change of the conditioned level on an interrupt-enabled pin sets that pin's sticky status bit. Only writing 1 to that bit at address 6 clears it, and a write of 0 leaves it set.
- R9: The interrupt output is 1 exactly when some status bit is set and its interrupt enable is 1. Clearing the enable drops the output but keeps the status bit.
- R10: The pull-down output equals the pin's pull-down bit. The pull-up output equals the pull-up bit except that it is 0 whenever the pull-down bit is also set.
- R11: Read data for the address presented with the read strobe appears on the read port after the next clock edge. Configuration registers read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| mclk_ok | input | 1 | Master clock present indication |
| tmo_tick | input | 1 | Single-cycle timeout tick pulse |
| src_divclk | input | 1 | Divided clock source |
| src_pll_lock | input | 1 | PLL lock status source |
| src_temp_ok | input | 1 | Temperature good source |
| src_sdata | input | 1 | Serial data out source |
| src_mic_det | input | 1 | Microphone detect source |
| src_mic_short | input | 1 | Microphone short source |
| pad_in | input | 4 | Input levels of pins 1, 3, 4, 5 |
| pad_out | output | 4 | Drive values of pins 1, 3, 4, 5 |
| pad_oe | output | 4 | Output enables of pins 1, 3, 4, 5 |
| pull_up | output | 4 | Pull-up controls of pins 1, 3, 4, 5 |
| pull_dn | output | 4 | Pull-down controls of pins 1, 3, 4, 5 |
| gpi_in | input | 2 | Input levels of pins 7 and 8 |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions assume four things about the inputs:
- the pad and source inputs are already synchronous to `clk`;
- `tmo_tick` is a pulse of one cycle;
- the register port never issues a write and a read of the same address that must be ordered;
- `mclk_ok` changes only between debounce windows.

The stimulus keeps to these assumptions. It changes pads, sources and strobes only at falling edges, holds each tick high for exactly one rising edge, and leaves several idle cycles after every configuration write or pad change before it samples a level or a status bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int NB = 4;          // bidirectional pins
  localparam int NI = 2;          // input-only pins
  localparam int NP = NB + NI;    // all conditioned pins
  localparam int AW = 3;
  localparam int WW = 8;
  localparam int RW = 16;
  localparam int LVL_LSB = 8;     // conditioned levels in the status word
  localparam int GPI_FIELD = 3;   // {irq, debounce, enable} per input-only pin

  localparam int A_CFG0 = 0;
  localparam int A_GPI  = NB;
  localparam int A_POL  = NB + 1;
  localparam int A_STAT = NB + 2;
  localparam int A_CTRL = NB + 3;

  typedef enum logic [3:0] {
    FN_INPUT    = 4'd0,
    FN_DIVCLK   = 4'd1,
    FN_LOW      = 4'd2,
    FN_HIGH     = 4'd3,
    FN_PLL      = 4'd4,
    FN_TEMP     = 4'd5,
    FN_SDATA    = 4'd6,
    FN_IRQ      = 4'd7,
    FN_MICDET   = 4'd8,
    FN_MICSHORT = 4'd9
  } fn_e;

  typedef struct packed {
    logic       pd;
    logic       pu;
    logic       irq_en;
    logic       deb_en;
    logic [3:0] sel;
  } bcfg_t;

  typedef struct packed {
    logic divclk;
    logic pll;
    logic temp;
    logic sdata;
    logic irq;
    logic mic_det;
    logic mic_short;
  } src_t;

  // A code drives the pad only when it names a defined source.
  function automatic logic fn_drives(input logic [3:0] s);
    return (s >= FN_DIVCLK) && (s <= FN_MICSHORT);
  endfunction

  function automatic logic fn_value(input logic [3:0] s, input src_t src);
    logic v;
    case (s)
      FN_DIVCLK:   v = src.divclk;
      FN_LOW:      v = 1'b0;
      FN_HIGH:     v = 1'b1;
      FN_PLL:      v = src.pll;
      FN_TEMP:     v = src.temp;
      FN_SDATA:    v = src.sdata;
      FN_IRQ:      v = src.irq;
      FN_MICDET:   v = src.mic_det;
      FN_MICSHORT: v = src.mic_short;
      default:     v = 1'b0;
    endcase
    return v;
  endfunction

  // Polarity register bit that serves conditioned pin index i.
  function automatic int pol_index(input int i);
    case (i)
      0:       return 0;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      4:       return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic pull_up_gate(input logic pu, input logic pd);
    return pu & ~pd;
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  re,
  input  logic [AW-1:0]         addr,
  input  logic [WW-1:0]         wdata,
  output logic [RW-1:0]         rdata,
  input  logic [NP-1:0]         status,
  input  logic [NP-1:0]         lvl,
  output bcfg_t [NB-1:0]        bcfg,
  output logic [NI-1:0]         gpi_en,
  output logic [NI-1:0]         gpi_deb,
  output logic [NI-1:0]         gpi_irq,
  output logic [NP-1:0]         pol_eff,
  output logic                  tmo_en,
  output logic [NP-1:0]         clr
);

  localparam int GW = GPI_FIELD * NI;

  logic [GW-1:0] gpi_q;
  logic [7:0]    pol_q;
  logic [RW-1:0] rd_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcfg   <= '0;
      gpi_q  <= '0;
      pol_q  <= '0;
      tmo_en <= 1'b0;
    end else if (we) begin
      for (int i = 0; i < NB; i++) begin
        if (addr == AW'(A_CFG0 + i)) bcfg[i] <= bcfg_t'(wdata);
      end
      if (addr == AW'(A_GPI))  gpi_q  <= wdata[GW-1:0];
      if (addr == AW'(A_POL))  pol_q  <= wdata;
      if (addr == AW'(A_CTRL)) tmo_en <= wdata[0];
    end
  end

  for (genvar j = 0; j < NI; j++) begin : g_gpi_fields
    assign gpi_en[j]  = gpi_q[GPI_FIELD*j];
    assign gpi_deb[j] = gpi_q[GPI_FIELD*j + 1];
    assign gpi_irq[j] = gpi_q[GPI_FIELD*j + 2];
  end

  for (genvar p = 0; p < NP; p++) begin : g_pol_map
    assign pol_eff[p] = pol_q[pol_index(p)];
  end

  assign clr = (we && addr == AW'(A_STAT)) ? wdata[NP-1:0] : '0;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == AW'(A_CFG0 + i)) rd_next[WW-1:0] = bcfg[i];
    end
    if (addr == AW'(A_GPI))  rd_next[GW-1:0] = gpi_q;
    if (addr == AW'(A_POL))  rd_next[7:0]    = pol_q;
    if (addr == AW'(A_STAT)) begin
      rd_next[NP-1:0]          = status;
      rd_next[LVL_LSB +: NP]   = lvl;
    end
    if (addr == AW'(A_CTRL)) rd_next[0] = tmo_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_cond.sv
module gpio_cond #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic inv,
  input  logic en,
  input  logic deb_on,
  input  logic tick,
  output logic lvl
);

  localparam int CW = $clog2(TICKS + 1);

  logic          smp;
  logic          stable;
  logic [CW-1:0] cnt;
  logic          accept;

  assign smp    = raw ^ inv;
  assign accept = tick && (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable <= 1'b0;
      cnt    <= '0;
    end else if (!deb_on) begin
      stable <= smp;
      cnt    <= '0;
    end else if (smp == stable) begin
      cnt <= '0;
    end else if (accept) begin
      stable <= smp;
      cnt    <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lvl = stable & en;

endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux
  import gpio_pkg::*;
(
  input  bcfg_t cfg,
  input  src_t  src,
  output logic  out,
  output logic  oe,
  output logic  pu,
  output logic  pd
);

  assign oe  = fn_drives(cfg.sel);
  assign out = fn_value(cfg.sel, src);
  assign pu  = pull_up_gate(cfg.pu, cfg.pd);
  assign pd  = cfg.pd;

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] arm,
  input  logic [N-1:0] ena,
  input  logic [N-1:0] clr,
  output logic [N-1:0] evt,
  output logic [N-1:0] status,
  output logic         irq
);

  logic [N-1:0] prev;

  assign evt = (lvl ^ prev) & arm & ena;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= '0;
      status <= '0;
    end else begin
      prev   <= lvl;
      status <= (status & ~clr) | evt;
    end
  end

  assign irq = |(status & ena);

endmodule

// File: rtl/gpio_mux_irq.sv
module gpio_mux_irq
  import gpio_pkg::*;
#(
  parameter int DEB_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          mclk_ok,
  input  logic          tmo_tick,
  input  logic          src_divclk,
  input  logic          src_pll_lock,
  input  logic          src_temp_ok,
  input  logic          src_sdata,
  input  logic          src_mic_det,
  input  logic          src_mic_short,
  input  logic [3:0]    pad_in,
  output logic [3:0]    pad_out,
  output logic [3:0]    pad_oe,
  output logic [3:0]    pull_up,
  output logic [3:0]    pull_dn,
  input  logic [1:0]    gpi_in,
  output logic          irq_o
);

  bcfg_t [NB-1:0]       bcfg;
  logic  [NB-1:0][3:0]  bsel;
  logic  [NI-1:0]       gpi_en;
  logic  [NI-1:0]       gpi_deb;
  logic  [NI-1:0]       gpi_irq;
  logic  [NP-1:0]       pol_eff;
  logic                 tmo_en;
  logic  [NP-1:0]       clr;
  logic  [NP-1:0]       lvl_q;
  logic  [NP-1:0]       lvl_en;
  logic  [NP-1:0]       deb_act;
  logic  [NP-1:0]       irq_en_vec;
  logic  [NP-1:0]       evt;
  logic  [NP-1:0]       status_q;
  src_t                 src;

  gpio_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .re      (reg_re),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .status  (status_q),
    .lvl     (lvl_q),
    .bcfg    (bcfg),
    .gpi_en  (gpi_en),
    .gpi_deb (gpi_deb),
    .gpi_irq (gpi_irq),
    .pol_eff (pol_eff),
    .tmo_en  (tmo_en),
    .clr     (clr)
  );

  assign src.divclk    = src_divclk;
  assign src.pll       = src_pll_lock;
  assign src.temp      = src_temp_ok;
  assign src.sdata     = src_sdata;
  assign src.irq       = irq_o;
  assign src.mic_det   = src_mic_det;
  assign src.mic_short = src_mic_short;

  for (genvar b = 0; b < NB; b++) begin : g_out
    assign bsel[b] = bcfg[b].sel;
    gpio_outmux u_mux (
      .cfg (bcfg[b]),
      .src (src),
      .out (pad_out[b]),
      .oe  (pad_oe[b]),
      .pu  (pull_up[b]),
      .pd  (pull_dn[b])
    );
  end

  for (genvar g = 0; g < NP; g++) begin : g_pin
    logic raw_w;
    logic deb_w;
    if (g < NB) begin : g_bidir
      assign raw_w         = pad_in[g];
      assign lvl_en[g]     = 1'b1;
      assign deb_w         = bcfg[g].deb_en;
      assign irq_en_vec[g] = bcfg[g].irq_en;
    end else begin : g_inonly
      assign raw_w         = gpi_in[g-NB];
      assign lvl_en[g]     = gpi_en[g-NB];
      assign deb_w         = gpi_deb[g-NB];
      assign irq_en_vec[g] = gpi_irq[g-NB];
    end
    assign deb_act[g] = deb_w & tmo_en & mclk_ok;

    gpio_cond #(.TICKS(DEB_TICKS)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_w),
      .inv    (pol_eff[g]),
      .en     (lvl_en[g]),
      .deb_on (deb_act[g]),
      .tick   (tmo_tick),
      .lvl    (lvl_q[g])
    );
  end

  gpio_irq #(.N(NP)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (lvl_q),
    .arm    (lvl_en),
    .ena    (irq_en_vec),
    .clr    (clr),
    .evt    (evt),
    .status (status_q),
    .irq    (irq_o)
  );

endmodule

// File: rtl/gpio_mux_irq_chk.sv
module gpio_mux_irq_chk
  import gpio_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [2:0]           reg_addr,
  input logic                 tmo_tick,
  input logic [3:0]           pad_out,
  input logic [3:0]           pad_oe,
  input logic [3:0]           pull_up,
  input logic [3:0]           pull_dn,
  input logic                 irq_o,
  input logic [NB-1:0][3:0]   bsel,
  input logic [NP-1:0]        status_q,
  input logic [NP-1:0]        irq_en_vec,
  input logic [NP-1:0]        lvl_q,
  input logic [NP-1:0]        lvl_en,
  input logic [NP-1:0]        deb_act
);

  for (genvar b = 0; b < NB; b++) begin : g_bidir_chk
    assert_reserved_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bsel[b] == 4'd0 || bsel[b] > 4'd9) |-> !pad_oe[b]);

    assert_const_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bsel[b] == 4'd2) |-> (pad_oe[b] && !pad_out[b]));

    assert_const_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bsel[b] == 4'd3) |-> (pad_oe[b] && pad_out[b]));
  end

  assert_pull_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pull_up & pull_dn) == 0);

  assert_status_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status_q) & ~status_q)) |-> $past(reg_we && reg_addr == 3'(A_STAT)));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_vec == '0) |-> !irq_o);

  for (genvar p = 0; p < NP; p++) begin : g_pin_chk
    assert_debounce_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (deb_act[p] && $past(deb_act[p]) && lvl_en[p] && $past(lvl_en[p]) &&
       (lvl_q[p] != $past(lvl_q[p]))) |-> $past(tmo_tick));
  end

  for (genvar j = 0; j < NI; j++) begin : g_gpi_chk
    assert_disabled_input_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!lvl_en[NB+j]) |-> !(status_q[NB+j] && !$past(status_q[NB+j])));
  end

endmodule

bind gpio_mux_irq gpio_mux_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .tmo_tick   (tmo_tick),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pull_up    (pull_up),
  .pull_dn    (pull_dn),
  .irq_o      (irq_o),
  .bsel       (bsel),
  .status_q   (status_q),
  .irq_en_vec (irq_en_vec),
  .lvl_q      (lvl_q),
  .lvl_en     (lvl_en),
  .deb_act    (deb_act)
);

// File: tb/test_gpio_mux_irq.sv
module test_gpio_mux_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mclk_ok = 1'b0;
  logic        tmo_tick = 1'b0;
  logic [5:0]  srcv = '0;   // [0] divclk [1] pll [2] temp [3] sdata [4] micdet [5] micshort
  logic [3:0]  pad_in = '0;
  logic [3:0]  pad_out;
  logic [3:0]  pad_oe;
  logic [3:0]  pull_up;
  logic [3:0]  pull_dn;
  logic [1:0]  gpi_in = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        re_q = 1'b0;

  always #2 clk = ~clk;

  gpio_mux_irq i_gpio_mux_irq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mclk_ok(mclk_ok), .tmo_tick(tmo_tick),
    .src_divclk(srcv[0]), .src_pll_lock(srcv[1]), .src_temp_ok(srcv[2]),
    .src_sdata(srcv[3]), .src_mic_det(srcv[4]), .src_mic_short(srcv[5]),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .gpi_in(gpi_in), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: compares each registered read result with the scoreboard head.
  always @(posedge clk) re_q <= reg_re;
  always @(negedge clk) begin
    if (re_q && exp_q.size() > 0) begin
      check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    idle(3);
  endtask

  // Driver: issues a read and pushes the expected word into the scoreboard.
  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
    idle(1);
  endtask

  task automatic pulse_tick(input int n);
    repeat (n) begin
      @(negedge clk); tmo_tick = 1'b1;
      @(negedge clk); tmo_tick = 1'b0;
    end
    idle(3);
  endtask

  function automatic logic [3:0] code_of(input int k);
    case (k)
      0: return 4'd1;
      1: return 4'd4;
      2: return 4'd5;
      3: return 4'd6;
      4: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (R1..all): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: quiet reset state
    check("R1 oe",   {12'd0, pad_oe},  16'd0);
    check("R1 pu",   {12'd0, pull_up}, 16'd0);
    check("R1 pd",   {12'd0, pull_dn}, 16'd0);
    check("R1 irq",  {15'd0, irq_o},   16'd0);
    rd(3'd0, 16'h0000, "R1 cfg0");
    rd(3'd4, 16'h0000, "R1 gpi");
    rd(3'd5, 16'h0000, "R1 pol");
    rd(3'd6, 16'h0000, "R1 status");
    rd(3'd7, 16'h0000, "R1 ctrl");

    // R2: constant drives
    wr(3'd0, 8'h02);
    check("R2 low oe",  {12'd0, pad_oe}, 16'h0001);
    check("R2 low out", {15'd0, pad_out[0]}, 16'd0);
    wr(3'd0, 8'h03);
    check("R2 high out", {15'd0, pad_out[0]}, 16'd1);

    // R3: source routing on pin 3
    for (int k = 0; k < 6; k++) begin
      srcv = 6'b1 << k;
      wr(3'd1, {4'h0, code_of(k)});
      check($sformatf("R3 code %0d oe", code_of(k)), {15'd0, pad_oe[1]}, 16'd1);
      check($sformatf("R3 code %0d one", code_of(k)), {15'd0, pad_out[1]}, 16'd1);
      srcv = ~(6'b1 << k);
      idle(1);
      check($sformatf("R3 code %0d zero", code_of(k)), {15'd0, pad_out[1]}, 16'd0);
    end
    srcv = '0;
    wr(3'd1, 8'h07);
    check("R3 irq route idle", {15'd0, pad_out[1]}, 16'd0);

    // R4: input and reserved codes leave the pad undriven
    wr(3'd1, 8'h00);
    check("R4 code 0", {15'd0, pad_oe[1]}, 16'd0);
    for (int c = 10; c < 16; c++) begin
      wr(3'd1, 8'(c));
      check($sformatf("R4 code %0d", c), {15'd0, pad_oe[1]}, 16'd0);
    end
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    check("R4 all inputs", {12'd0, pad_oe}, 16'd0);

    // R10: pull controls
    wr(3'd2, 8'h40);
    check("R10 pu only up", {12'd0, pull_up}, 16'h0004);
    check("R10 pu only dn", {12'd0, pull_dn}, 16'h0000);
    wr(3'd2, 8'hC0);
    check("R10 both up", {12'd0, pull_up}, 16'h0000);
    check("R10 both dn", {12'd0, pull_dn}, 16'h0004);
    rd(3'd2, 16'h00C0, "R11 cfg2 readback");
    wr(3'd2, 8'hB5);
    rd(3'd2, 16'h00B5, "R11 cfg2 pattern");
    wr(3'd2, 8'h00);

    // R5: polarity mapping, reserved bits inert
    wr(3'd4, 8'h09);
    rd(3'd4, 16'h0009, "R11 gpi readback");
    wr(3'd5, 8'h22);
    rd(3'd5, 16'h0022, "R5 reserved readback");
    rd(3'd6, 16'h0000, "R5 reserved no effect");
    wr(3'd5, 8'h01);
    rd(3'd6, 16'h0100, "R5 bit0 pin1");
    wr(3'd5, 8'h80);
    rd(3'd6, 16'h2000, "R5 bit7 pin8");
    wr(3'd5, 8'h5C);
    rd(3'd6, 16'h1E00, "R5 bits 6,4,3,2");

    // R6: disabled input-only pin
    wr(3'd5, 8'h40);
    rd(3'd6, 16'h1000, "R6 pin7 enabled");
    wr(3'd4, 8'h0C);
    rd(3'd6, 16'h0000, "R6 pin7 disabled level");
    wr(3'd5, 8'h00);
    gpi_in[0] = 1'b1;
    idle(3);
    wr(3'd5, 8'h40);
    rd(3'd6, 16'h0000, "R6 pin7 no status");
    check("R6 irq", {15'd0, irq_o}, 16'd0);
    wr(3'd4, 8'h08);
    wr(3'd5, 8'h00);
    gpi_in[0] = 1'b0;
    idle(3);

    // R8 / R9: change interrupts on pin 3
    wr(3'd1, 8'h20);
    pad_in[1] = 1'b1;
    idle(3);
    check("R9 irq set", {15'd0, irq_o}, 16'd1);
    rd(3'd6, 16'h0202, "R8 status set");
    wr(3'd3, 8'h07);
    check("R3 irq route", {15'd0, pad_out[3]}, 16'd1);
    wr(3'd3, 8'h00);
    wr(3'd6, 8'h01);
    rd(3'd6, 16'h0202, "R8 other bit write keeps");
    wr(3'd6, 8'h00);
    rd(3'd6, 16'h0202, "R8 zero write keeps");
    wr(3'd6, 8'h02);
    check("R9 irq cleared", {15'd0, irq_o}, 16'd0);
    rd(3'd6, 16'h0200, "R8 cleared");
    pad_in[2] = 1'b1;
    idle(3);
    check("R8 no enable no irq", {15'd0, irq_o}, 16'd0);
    rd(3'd6, 16'h0600, "R8 no enable no status");
    pad_in[1] = 1'b0;
    idle(3);
    check("R8 falling edge irq", {15'd0, irq_o}, 16'd1);
    rd(3'd6, 16'h0402, "R8 falling edge status");
    wr(3'd1, 8'h00);
    check("R9 enable off", {15'd0, irq_o}, 16'd0);
    rd(3'd6, 16'h0402, "R9 status kept");
    wr(3'd6, 8'h3F);
    rd(3'd6, 16'h0400, "R8 clear all");

    // R7: debounce on pin 1
    mclk_ok = 1'b1;
    wr(3'd7, 8'h01);
    rd(3'd7, 16'h0001, "R11 ctrl readback");
    wr(3'd0, 8'h10);
    pad_in[0] = 1'b1;
    idle(3);
    rd(3'd6, 16'h0400, "R7 no tick no change");
    pulse_tick(3);
    rd(3'd6, 16'h0400, "R7 three ticks");
    pulse_tick(1);
    rd(3'd6, 16'h0500, "R7 fourth tick");
    pad_in[0] = 1'b0;
    idle(2);
    pulse_tick(2);
    pad_in[0] = 1'b1;
    idle(3);
    pad_in[0] = 1'b0;
    idle(2);
    pulse_tick(2);
    rd(3'd6, 16'h0500, "R7 bounce restarts count");
    pulse_tick(2);
    rd(3'd6, 16'h0400, "R7 settled low");
    mclk_ok = 1'b0;
    pad_in[0] = 1'b1;
    idle(3);
    rd(3'd6, 16'h0500, "R7 no mclk passthrough");
    mclk_ok = 1'b1;
    wr(3'd7, 8'h00);
    pad_in[0] = 1'b0;
    idle(3);
    rd(3'd6, 16'h0400, "R7 tick disabled passthrough");

    idle(4);
    summary();
    $finish;
  end

endmodule